// File: doc/BRIEF.md
# Shared Request/Response Mailbox with Ownership Handoff

This block is a 256-bit message window shared by two agents. A requester fills it through a 32-bit register port that addresses eight dwords, at byte offsets 0, 4, 8 and so on up to 28. The dword index is the port address, and the byte offset is the index times four. A server reads the request through a second port of its own and writes its answer back. A single ownership flag decides which side may change the window.

The last dword (index 7, byte offset 28) carries the protocol header. When the requester writes it, ownership passes to the server, and the server gets a one-cycle notification. When the server writes its reply header to that dword, ownership returns to the requester.

Header layout:

| Bits | Field |
|------|-------|
| 2:0 | Message type |
| 5:3 | Version |
| 6 | Reserved |
| 7 | Direction: 0 for a request, 1 for a response |
| 15:8 | Status |
| 23:16 | Reserved |
| 24 | Reset-function flag |
| 30:25 | Reserved |
| 31 | Owner: 1 means the server owns the window, 0 means the requester owns it |

A separate reset-indication input makes every requester read return all ones while it is high.

Top module: `mbox_handoff`

## Requirements
- R1: After a synchronous reset, every dword reads as zero on both read ports, `srv_owns` is 0 and `srv_req_pulse` is 0.
- R2: While the requester owns the window, a requester write to dwords 0 to 6 is stored. A requester read returns the stored value on `req_rd_data` one cycle after the read is issued.
- R3: A requester write to dword 7 while it owns the window stores bits 30:0 as written and forces bit 31 (the owner bit) to 1. From the next cycle `srv_owns` is 1.
- R4: Each requester write that hands over ownership produces exactly one `srv_req_pulse`, high for a single cycle, aligned with `srv_owns` first going high.
- R5: While the server owns the window, requester writes to any dword have no effect on the stored contents or on ownership.
- R6: The server read port returns any dword's stored value on `srv_rd_data` one cycle after the read is issued.
- R7: While the server owns the window, a server write to dwords 0 to 6 is stored. A server write to dword 7 stores bits 30:0 and forces bit 31 to 0, and `srv_owns` is 0 from the next cycle.
- R8: While the requester owns the window, server writes to any dword have no effect on the stored contents or on ownership.
- R9: While `req_fn_reset` is 1, each requester read returns 0xFFFFFFFF on `req_rd_data`. The server port and the stored contents are unaffected.
- R10: A synchronous reset applied after traffic returns ownership to the requester and makes every previously written dword read as zero.
- R11: `srv_msg_type`, `srv_msg_ver` and `srv_reset_fn` show header bits 2:0, 5:3 and 24 of the stored dword 7. They change only when dword 7 is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_fn_reset | input | 1 | Requester reset indication; requester reads return all ones while it is high |
| req_wr_en | input | 1 | Requester write strobe |
| req_wr_idx | input | 3 | Requester write dword index (byte offset divided by 4) |
| req_wr_data | input | 32 | Requester write data |
| req_rd_en | input | 1 | Requester read strobe |
| req_rd_idx | input | 3 | Requester read dword index |
| req_rd_data | output | 32 | Requester read data, valid one cycle after `req_rd_en` |
| srv_wr_en | input | 1 | Server write strobe |
| srv_wr_idx | input | 3 | Server write dword index |
| srv_wr_data | input | 32 | Server write data |
| srv_rd_en | input | 1 | Server read strobe |
| srv_rd_idx | input | 3 | Server read dword index |
| srv_rd_data | output | 32 | Server read data, valid one cycle after `srv_rd_en` |
| srv_owns | output | 1 | Current owner bit: 1 means the server owns the window |
| srv_req_pulse | output | 1 | One-cycle notification of a new request |
| srv_msg_type | output | 3 | Message type from the stored header |
| srv_msg_ver | output | 3 | Version from the stored header |
| srv_reset_fn | output | 1 | Reset-function flag from the stored header |

## Verification
The timing follows from the registers on each path:
- Both read ports have one cycle of latency.
- A write updates the stored contents, `srv_owns`, `srv_req_pulse` and the decoded header fields at the clock edge that samples it.

The bench drives each stimulus on a falling edge and holds it across one rising edge. For a read, it samples the data at the following falling edge. For a write, it samples ownership and the notification pulse at that same falling edge. It checks that the pulse has dropped one falling edge later.

Tests of ignored writes read the affected dwords and the owner flag back through the normal ports before the next stimulus. This shows that nothing changed.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Ownership encoding held in the top bit of the header dword.
  typedef enum logic {
    OWN_REQ = 1'b0,
    OWN_SRV = 1'b1
  } owner_e;

  // Header field positions; the server decodes these.
  localparam int TYPE_LSB  = 0;
  localparam int TYPE_W    = 3;
  localparam int VER_LSB   = 3;
  localparam int VER_W     = 3;
  localparam int DIR_BIT   = 7;
  localparam int STAT_LSB  = 8;
  localparam int STAT_W    = 8;
  localparam int RSTFN_BIT = 24;

endpackage

// File: rtl/mbox_dpram.sv
// One write port and two registered read ports; written without reset so it maps to block RAM.
module mbox_dpram #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              a_en,
  input  logic [AW-1:0]     a_addr,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_en,
  input  logic [AW-1:0]     b_addr,
  output logic [DATA_W-1:0] b_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en) b_q <= mem[b_addr];
  end

endmodule

// File: rtl/mbox_owner_ctrl.sv
// Holds the header dword, the owner bit and per-dword written flags; steers the shared write port.
module mbox_owner_ctrl #(
  parameter int DWORDS = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W   = $clog2(DWORDS),
  localparam int LAST    = DWORDS - 1,
  localparam int OWN_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr_en,
  input  logic [IDX_W-1:0]  req_wr_idx,
  input  logic [DATA_W-1:0] req_wr_data,
  input  logic              srv_wr_en,
  input  logic [IDX_W-1:0]  srv_wr_idx,
  input  logic [DATA_W-1:0] srv_wr_data,
  output logic [DATA_W-1:0] hdr_q,
  output logic              owns_srv,
  output logic              req_pulse,
  output logic [DWORDS-1:0] dw_valid,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_waddr,
  output logic [DATA_W-1:0] ram_wdata
);
  import mbox_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

  owner_e owner;
  logic   req_take, srv_take, req_last, srv_last;
  logic   hand_over, hand_back;

  assign owner     = owner_e'(hdr_q[OWN_BIT]);
  assign owns_srv  = (owner == OWN_SRV);

  assign req_last  = (req_wr_idx == LAST_IDX);
  assign srv_last  = (srv_wr_idx == LAST_IDX);
  assign req_take  = req_wr_en && (owner == OWN_REQ);
  assign srv_take  = srv_wr_en && (owner == OWN_SRV);
  assign hand_over = req_take && req_last;
  assign hand_back = srv_take && srv_last;

  // Only the current owner reaches the shared write port, so no arbitration is needed.
  assign ram_we    = (req_take && !req_last) || (srv_take && !srv_last);
  assign ram_waddr = (owner == OWN_SRV) ? srv_wr_idx  : req_wr_idx;
  assign ram_wdata = (owner == OWN_SRV) ? srv_wr_data : req_wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q     <= '0;
      req_pulse <= 1'b0;
    end else begin
      req_pulse <= hand_over;
      if (hand_over)
        hdr_q <= {OWN_SRV, req_wr_data[OWN_BIT-1:0]};
      else if (hand_back)
        hdr_q <= {OWN_REQ, srv_wr_data[OWN_BIT-1:0]};
    end
  end

  // Written flags stand in for clearing the RAM on reset.
  always_ff @(posedge clk) begin
    if (rst) dw_valid <= '0;
    else if (ram_we) dw_valid[ram_waddr] <= 1'b1;
  end

endmodule

// File: rtl/mbox_rd_sel.sv
// Read-side selection: header register, RAM word (masked when never written) or forced all ones.
module mbox_rd_sel #(
  parameter int DWORDS = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DWORDS),
  localparam int LAST  = DWORDS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              force_ones,
  input  logic [DATA_W-1:0] hdr,
  input  logic [DWORDS-1:0] dw_valid,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

  logic              sel_hdr_q, valid_q, ones_q;
  logic [DATA_W-1:0] hdr_snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_hdr_q  <= 1'b0;
      valid_q    <= 1'b0;
      ones_q     <= 1'b0;
      hdr_snap_q <= '0;
    end else if (rd_en) begin
      sel_hdr_q  <= (rd_idx == LAST_IDX);
      valid_q    <= dw_valid[rd_idx];
      ones_q     <= force_ones;
      hdr_snap_q <= hdr;
    end
  end

  always_comb begin
    if (ones_q)         rd_data = '1;
    else if (sel_hdr_q) rd_data = hdr_snap_q;
    else if (valid_q)   rd_data = ram_q;
    else                rd_data = '0;
  end

endmodule

// File: rtl/mbox_handoff.sv
module mbox_handoff #(
  parameter int DWORDS = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_fn_reset,
  input  logic              req_wr_en,
  input  logic [IDX_W-1:0]  req_wr_idx,
  input  logic [DATA_W-1:0] req_wr_data,
  input  logic              req_rd_en,
  input  logic [IDX_W-1:0]  req_rd_idx,
  output logic [DATA_W-1:0] req_rd_data,
  input  logic              srv_wr_en,
  input  logic [IDX_W-1:0]  srv_wr_idx,
  input  logic [DATA_W-1:0] srv_wr_data,
  input  logic              srv_rd_en,
  input  logic [IDX_W-1:0]  srv_rd_idx,
  output logic [DATA_W-1:0] srv_rd_data,
  output logic              srv_owns,
  output logic              srv_req_pulse,
  output logic [2:0]        srv_msg_type,
  output logic [2:0]        srv_msg_ver,
  output logic              srv_reset_fn
);
  import mbox_pkg::*;

  logic [DATA_W-1:0] hdr_q;
  logic [DWORDS-1:0] dw_valid;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_req_q, ram_srv_q;

  mbox_owner_ctrl #(.DWORDS(DWORDS), .DATA_W(DATA_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .req_wr_en   (req_wr_en),
    .req_wr_idx  (req_wr_idx),
    .req_wr_data (req_wr_data),
    .srv_wr_en   (srv_wr_en),
    .srv_wr_idx  (srv_wr_idx),
    .srv_wr_data (srv_wr_data),
    .hdr_q       (hdr_q),
    .owns_srv    (srv_owns),
    .req_pulse   (srv_req_pulse),
    .dw_valid    (dw_valid),
    .ram_we      (ram_we),
    .ram_waddr   (ram_waddr),
    .ram_wdata   (ram_wdata)
  );

  mbox_dpram #(.DEPTH(DWORDS), .DATA_W(DATA_W)) ram_i (
    .clk    (clk),
    .we     (ram_we),
    .waddr  (ram_waddr),
    .wdata  (ram_wdata),
    .a_en   (req_rd_en),
    .a_addr (req_rd_idx),
    .a_q    (ram_req_q),
    .b_en   (srv_rd_en),
    .b_addr (srv_rd_idx),
    .b_q    (ram_srv_q)
  );

  mbox_rd_sel #(.DWORDS(DWORDS), .DATA_W(DATA_W)) req_rd_i (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (req_rd_en),
    .rd_idx     (req_rd_idx),
    .force_ones (req_fn_reset),
    .hdr        (hdr_q),
    .dw_valid   (dw_valid),
    .ram_q      (ram_req_q),
    .rd_data    (req_rd_data)
  );

  mbox_rd_sel #(.DWORDS(DWORDS), .DATA_W(DATA_W)) srv_rd_i (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (srv_rd_en),
    .rd_idx     (srv_rd_idx),
    .force_ones (1'b0),
    .hdr        (hdr_q),
    .dw_valid   (dw_valid),
    .ram_q      (ram_srv_q),
    .rd_data    (srv_rd_data)
  );

  assign srv_msg_type = hdr_q[TYPE_LSB +: TYPE_W];
  assign srv_msg_ver  = hdr_q[VER_LSB +: VER_W];
  assign srv_reset_fn = hdr_q[RSTFN_BIT];

endmodule

// File: rtl/mbox_handoff_chk.sv
module mbox_handoff_chk #(
  parameter int DWORDS = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DWORDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_fn_reset,
  input logic              req_wr_en,
  input logic [IDX_W-1:0]  req_wr_idx,
  input logic              req_rd_en,
  input logic [DATA_W-1:0] req_rd_data,
  input logic              srv_wr_en,
  input logic [IDX_W-1:0]  srv_wr_idx,
  input logic              srv_owns,
  input logic              srv_req_pulse,
  input logic [2:0]        srv_msg_type
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DWORDS - 1);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!srv_owns && !srv_req_pulse));

  // R3
  handover_chk: assert property (@(posedge clk) disable iff (rst)
    (req_wr_en && req_wr_idx == LAST_IDX && !srv_owns) |=> srv_owns);

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    srv_req_pulse |=> !srv_req_pulse);

  // R4
  pulse_align_chk: assert property (@(posedge clk) disable iff (rst)
    srv_req_pulse |-> srv_owns);

  // R5
  srv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (srv_owns && !(srv_wr_en && srv_wr_idx == LAST_IDX)) |=> (srv_owns && $stable(srv_msg_type)));

  // R7
  handback_chk: assert property (@(posedge clk) disable iff (rst)
    (srv_owns && srv_wr_en && srv_wr_idx == LAST_IDX) |=> !srv_owns);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!srv_owns && !(req_wr_en && req_wr_idx == LAST_IDX)) |=> (!srv_owns && !srv_req_pulse));

  // R9
  fn_reset_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (req_rd_en && req_fn_reset) |=> (req_rd_data == '1));

endmodule

bind mbox_handoff mbox_handoff_chk #(.DWORDS(DWORDS), .DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_fn_reset  (req_fn_reset),
  .req_wr_en     (req_wr_en),
  .req_wr_idx    (req_wr_idx),
  .req_rd_en     (req_rd_en),
  .req_rd_data   (req_rd_data),
  .srv_wr_en     (srv_wr_en),
  .srv_wr_idx    (srv_wr_idx),
  .srv_owns      (srv_owns),
  .srv_req_pulse (srv_req_pulse),
  .srv_msg_type  (srv_msg_type)
);

// File: tb/mbox_handoff_tb_top.sv
`timescale 1ns/1ps
module mbox_handoff_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_fn_reset = 1'b0;
  logic        req_wr_en = 1'b0;
  logic [2:0]  req_wr_idx = '0;
  logic [31:0] req_wr_data = '0;
  logic        req_rd_en = 1'b0;
  logic [2:0]  req_rd_idx = '0;
  logic [31:0] req_rd_data;
  logic        srv_wr_en = 1'b0;
  logic [2:0]  srv_wr_idx = '0;
  logic [31:0] srv_wr_data = '0;
  logic        srv_rd_en = 1'b0;
  logic [2:0]  srv_rd_idx = '0;
  logic [31:0] srv_rd_data;
  logic        srv_owns, srv_req_pulse, srv_reset_fn;
  logic [2:0]  srv_msg_type, srv_msg_ver;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  mbox_handoff dut_i (
    .clk(clk), .rst(rst), .req_fn_reset(req_fn_reset),
    .req_wr_en(req_wr_en), .req_wr_idx(req_wr_idx), .req_wr_data(req_wr_data),
    .req_rd_en(req_rd_en), .req_rd_idx(req_rd_idx), .req_rd_data(req_rd_data),
    .srv_wr_en(srv_wr_en), .srv_wr_idx(srv_wr_idx), .srv_wr_data(srv_wr_data),
    .srv_rd_en(srv_rd_en), .srv_rd_idx(srv_rd_idx), .srv_rd_data(srv_rd_data),
    .srv_owns(srv_owns), .srv_req_pulse(srv_req_pulse),
    .srv_msg_type(srv_msg_type), .srv_msg_ver(srv_msg_ver), .srv_reset_fn(srv_reset_fn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic req_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    req_wr_en = 1'b1; req_wr_idx = idx; req_wr_data = d;
    @(negedge clk);
    req_wr_en = 1'b0;
  endtask

  task automatic srv_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    srv_wr_en = 1'b1; srv_wr_idx = idx; srv_wr_data = d;
    @(negedge clk);
    srv_wr_en = 1'b0;
  endtask

  task automatic req_rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    req_rd_en = 1'b1; req_rd_idx = idx;
    @(negedge clk);
    req_rd_en = 1'b0;
    d = req_rd_data;
  endtask

  task automatic srv_rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    srv_rd_en = 1'b1; srv_rd_idx = idx;
    @(negedge clk);
    srv_rd_en = 1'b0;
    d = srv_rd_data;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 + 32'(i) * 32'h0000_0111;
  endfunction

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    chk("R1 owner after reset", {31'd0, srv_owns}, 32'd0);
    chk("R1 pulse after reset", {31'd0, srv_req_pulse}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      req_rd(3'(i), d);
      chk("R1 requester dword zero", d, 32'd0);
      srv_rd(3'(i), d);
      chk("R1 server dword zero", d, 32'd0);
    end
  endtask

  task automatic t_data_rw();
    logic [31:0] d;
    for (int i = 0; i < 7; i++) req_wr(3'(i), pat(i));
    for (int i = 0; i < 7; i++) begin
      req_rd(3'(i), d);
      chk("R2 data readback", d, pat(i));
    end
    chk("R2 still requester owned", {31'd0, srv_owns}, 32'd0);
  endtask

  task automatic t_handover();
    logic [31:0] d;
    req_wr(3'd7, 32'h0100_0009);
    chk("R3 owner set", {31'd0, srv_owns}, 32'd1);
    chk("R4 pulse high", {31'd0, srv_req_pulse}, 32'd1);
    @(negedge clk);
    chk("R4 pulse single cycle", {31'd0, srv_req_pulse}, 32'd0);
    chk("R11 type", {29'd0, srv_msg_type}, 32'd1);
    chk("R11 version", {29'd0, srv_msg_ver}, 32'd1);
    chk("R11 reset flag", {31'd0, srv_reset_fn}, 32'd1);
    req_rd(3'd7, d);
    chk("R3 header with owner bit", d, 32'h8100_0009);
  endtask

  task automatic t_locked_writes();
    logic [31:0] d;
    req_wr(3'd2, 32'h0000_DEAD);
    req_wr(3'd7, 32'h0000_0002);
    chk("R5 no pulse on locked write", {31'd0, srv_req_pulse}, 32'd0);
    chk("R5 owner kept", {31'd0, srv_owns}, 32'd1);
    req_rd(3'd2, d);
    chk("R5 data unchanged", d, pat(2));
    req_rd(3'd7, d);
    chk("R5 header unchanged", d, 32'h8100_0009);
    chk("R11 type unchanged", {29'd0, srv_msg_type}, 32'd1);
  endtask

  task automatic t_server_view();
    logic [31:0] d;
    srv_rd(3'd2, d);
    chk("R6 server reads data", d, pat(2));
    srv_rd(3'd7, d);
    chk("R6 server reads header", d, 32'h8100_0009);
  endtask

  task automatic t_server_reply();
    logic [31:0] d;
    srv_wr(3'd1, 32'h1234_5678);
    chk("R7 payload write keeps owner", {31'd0, srv_owns}, 32'd1);
    srv_wr(3'd7, 32'h8000_0389);
    chk("R7 owner returned", {31'd0, srv_owns}, 32'd0);
    req_rd(3'd7, d);
    chk("R7 reply header owner cleared", d, 32'h0000_0389);
    req_rd(3'd1, d);
    chk("R7 server payload visible", d, 32'h1234_5678);
    chk("R11 reply reset flag", {31'd0, srv_reset_fn}, 32'd0);
  endtask

  task automatic t_server_ignored();
    logic [31:0] d;
    srv_wr(3'd0, 32'h0000_0BAD);
    srv_wr(3'd7, 32'h0000_00FF);
    chk("R8 owner unchanged", {31'd0, srv_owns}, 32'd0);
    req_rd(3'd0, d);
    chk("R8 data unchanged", d, pat(0));
    req_rd(3'd7, d);
    chk("R8 header unchanged", d, 32'h0000_0389);
  endtask

  task automatic t_fn_reset();
    logic [31:0] d;
    @(negedge clk) req_fn_reset = 1'b1;
    req_rd(3'd7, d);
    chk("R9 last dword all ones", d, 32'hFFFF_FFFF);
    req_rd(3'd4, d);
    chk("R9 data dword all ones", d, 32'hFFFF_FFFF);
    srv_rd(3'd4, d);
    chk("R9 server unaffected", d, pat(4));
    @(negedge clk) req_fn_reset = 1'b0;
    req_rd(3'd4, d);
    chk("R9 contents kept", d, pat(4));
  endtask

  task automatic t_reset_after_traffic();
    logic [31:0] d;
    req_wr(3'd7, 32'h0000_0002);
    chk("R10 owner before reset", {31'd0, srv_owns}, 32'd1);
    do_reset();
    chk("R10 owner cleared", {31'd0, srv_owns}, 32'd0);
    req_rd(3'd1, d);
    chk("R10 data cleared", d, 32'd0);
    req_rd(3'd7, d);
    chk("R10 header cleared", d, 32'd0);
    srv_rd(3'd5, d);
    chk("R10 server view cleared", d, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    t_reset_state();
    t_data_rw();
    t_handover();
    t_locked_writes();
    t_server_view();
    t_server_reply();
    t_server_ignored();
    t_fn_reset();
    t_reset_after_traffic();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule